// File: doc/BRIEF.md
# PLL Bypass and Relock Sequencer

This block controls a PLL so that its multiplier or dividers can be reprogrammed safely. The output is moved onto the reference clock first, and the PLL returns to the output only after it has locked again. It drives a 9-bit control word. When the block is idle, software can write that word directly through a plain write-enable and data port.

A switch has two phases:

- **Bypass phase.** A bypass request starts it. The block routes the output to the reference clock, waits a fixed number of reference cycles, and then holds the PLL in reset with its disable bit cleared.
- **Relock phase.** An apply request starts it, once the new settings are in place. The block waits a reset hold time and releases reset. It then waits for lock and only then sets the output-enable bit.

A small saturating counter stands in for the analog PLL's lock detector. The busy flag covers the whole switch.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset the control word is 0x010: only bit 4 (disable) is set, bit 3 (active-low PLL reset) is 0 and bit 0 (output enable) is 0. Busy and locked are low.
- R2: While idle, a write loads the whole control word at the next edge. While busy, writes have no effect.
- R3: A bypass request while idle clears bit 0 and bit 5 (output source) at the next edge and raises busy at that same edge. All other bits keep their values.
- R4: Bits 3 and 4 both clear exactly BYP_CYC cycles after the bypass entry edge.
- R5: An apply request in the waiting state sets bit 3 exactly RST_CYC cycles after the edge that samples it.
- R6: An apply request during the bypass wait is held. Bit 3 is then set RST_CYC cycles after the bypass wait ends.
- R7: The lock stand-in raises locked LOCK_CYC cycles after bit 3 is set, while bits 4 and 1 (power-down) are clear. Locked drops once bit 4 or bit 1 is set or bit 3 is cleared.
- R8: During relock, bit 0 is set at the edge after locked is seen, and busy falls at that same edge. The final word keeps bit 3 set, bits 4 and 5 clear, and bits 8..6 and 2..1 as they were.
- R9: A bypass request while busy has no effect. An apply request while idle, or after the apply has been taken, also has no effect.
- R10: A bypass request takes priority over a write presented in the same idle cycle; the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all waits are counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bypass_req_i | input | 1 | Start the bypass phase |
| apply_req_i | input | 1 | New settings ready; start the relock phase |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 9 | Control word write data |
| ctrl_o | output | 9 | Control word: bit0 output enable, bit1 power-down, bit3 reset (0 holds reset), bit4 disable, bit5 source, bit8 clock mode |
| busy_o | output | 1 | A switch is in progress |
| locked_o | output | 1 | Lock stand-in reports lock |

## Verification
Some properties are checked on every cycle:

- a bypass request from idle always lands in bypass with busy set;
- the fields the sequence does not own never move while busy;
- output enable never returns during a sequence without prior lock;
- lock never rises without a released reset.

The exact wait lengths need the bench scenarios. So do the hold-over of an early apply request, the dropping of requests and writes mid-sequence, and the request-over-write priority. The bench sweeps the apply request across every cycle offset around the end of the bypass wait.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned CTRL_W   = 9;
  localparam int unsigned BIT_OE   = 0;
  localparam int unsigned BIT_PD   = 1;
  localparam int unsigned BIT_RST  = 3;
  localparam int unsigned BIT_DIS  = 4;
  localparam int unsigned BIT_SRC  = 5;
  localparam int unsigned BIT_MODE = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(1 << BIT_DIS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP_WAIT,
    ST_WAIT_APPLY,
    ST_RST_HOLD,
    ST_LOCK_WAIT
  } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == last_i);
endmodule

// File: rtl/lock_model.sv
module lock_model #(
  parameter int unsigned LOCK_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic locked_o
);
  localparam int unsigned LK_W = $clog2(LOCK_CYC + 1);
  localparam logic [LK_W-1:0] LK_MAX = LK_W'(LOCK_CYC);

  logic [LK_W-1:0] cnt_q;
  logic            full;

  assign full = (cnt_q == LK_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!full)  cnt_q <= cnt_q + 1'b1;
  end

  assign locked_o = run_i && full;
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned BYP_CYC  = 4,
  parameter int unsigned RST_CYC  = 25,
  parameter int unsigned LOCK_CYC = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_req_i,
  input  logic              apply_req_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              busy_o,
  output logic              locked_o
);
  localparam int unsigned MAX_WAIT = (BYP_CYC > RST_CYC) ? BYP_CYC : RST_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] BYP_LAST = CNT_W'(BYP_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);

  seq_state_e        state_q, state_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              pend_q, pend_d;
  logic              t_done, t_run, t_clr, pll_run, pll_locked;
  logic [CNT_W-1:0]  t_last;

  assign t_run  = (state_q == ST_BYP_WAIT) || (state_q == ST_RST_HOLD);
  assign t_clr  = (state_d != state_q);
  assign t_last = (state_q == ST_BYP_WAIT) ? BYP_LAST : RST_LAST;

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (t_clr),
    .run_i  (t_run),
    .last_i (t_last),
    .done_o (t_done)
  );

  // stand-in for the analog loop: counts while out of reset and powered
  assign pll_run = ctrl_q[BIT_RST] && !ctrl_q[BIT_DIS] && !ctrl_q[BIT_PD];

  lock_model #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pll_run),
    .locked_o (pll_locked)
  );

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (bypass_req_i) begin
          ctrl_d[BIT_OE]  = 1'b0;
          ctrl_d[BIT_SRC] = 1'b0;
          pend_d          = 1'b0;
          state_d         = ST_BYP_WAIT;
        end else if (wr_en_i) begin
          ctrl_d = wr_data_i;
        end
      end
      ST_BYP_WAIT: begin
        if (apply_req_i) pend_d = 1'b1;
        if (t_done) begin
          ctrl_d[BIT_RST] = 1'b0;
          ctrl_d[BIT_DIS] = 1'b0;
          pend_d          = 1'b0;
          state_d         = (pend_q || apply_req_i) ? ST_RST_HOLD : ST_WAIT_APPLY;
        end
      end
      ST_WAIT_APPLY: begin
        if (apply_req_i) state_d = ST_RST_HOLD;
      end
      ST_RST_HOLD: begin
        if (t_done) begin
          ctrl_d[BIT_RST] = 1'b1;
          state_d         = ST_LOCK_WAIT;
        end
      end
      ST_LOCK_WAIT: begin
        if (pll_locked) begin
          ctrl_d[BIT_OE] = 1'b1;
          state_d        = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= CTRL_RESET;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign locked_o = pll_locked;
endmodule

// File: rtl/pll_relock_seq_chk.sv
module pll_relock_seq_chk
  import pll_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_req_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              busy_o,
  input logic              locked_o
);
  a_r3_bypass_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_req_i && !busy_o) |=> (busy_o && !ctrl_o[BIT_OE] && !ctrl_o[BIT_SRC]));

  a_r2_fields_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(ctrl_o[8:5]) && $stable(ctrl_o[2:1])));

  a_r8_oe_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_o[BIT_OE]) && $past(busy_o)) |-> ($past(locked_o) && !busy_o));

  a_r7_lock_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(ctrl_o[BIT_RST]) && !$past(ctrl_o[BIT_DIS])));
endmodule

bind pll_relock_seq pll_relock_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bypass_req_i (bypass_req_i),
  .ctrl_o       (ctrl_o),
  .busy_o       (busy_o),
  .locked_o     (locked_o)
);

// File: tb/sim_pll_relock_seq.sv
`timescale 1ns/1ps
module sim_pll_relock_seq;
  localparam int BYP  = 4;
  localparam int RST  = 5;
  localparam int LOCK = 12;
  localparam logic [8:0] RUN_WORD = 9'h129;  // oe, rst released, src, mode
  localparam logic [8:0] END_WORD = 9'h109;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bypass_req = 1'b0, apply_req = 1'b0, wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] ctrl;
  logic       busy, locked;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  pll_relock_seq #(.BYP_CYC(BYP), .RST_CYC(RST), .LOCK_CYC(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_req_i(bypass_req), .apply_req_i(apply_req),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_o(ctrl), .busy_o(busy), .locked_o(locked));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [8:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_seq(input int d, input bit disturb);
    int aoff, t_rf, t_rr, t_lk, t_dn;
    aoff = (d <= BYP) ? BYP : d;
    t_rf = -1; t_rr = -1; t_lk = -1; t_dn = -1;
    bypass_req = 1'b1;
    @(negedge clk);
    bypass_req = 1'b0;
    for (int k = 0; k < 200; k++) begin
      apply_req = 1'b0; bypass_req = 1'b0; wr_en = 1'b0;
      if (k == 0) begin
        chk(busy === 1'b1, "R3 busy", busy, 1);
        chk(ctrl === (RUN_WORD & ~9'h021), "R3 bypass word", ctrl, RUN_WORD & ~9'h021);
      end
      if (t_rf < 0 && !ctrl[3] && !ctrl[4]) t_rf = k;
      if (t_rf >= 0 && t_rr < 0 && ctrl[3]) t_rr = k;
      if (t_rr >= 0 && t_lk < 0 && locked) t_lk = k;
      if (!busy) begin t_dn = k; break; end
      if (k + 1 == d) apply_req = 1'b1;
      if (disturb && k + 1 == BYP + 1) begin
        bypass_req = 1'b1; wr_en = 1'b1; wr_data = 9'h1FF;
      end
      if (disturb && k + 1 == aoff + 2) apply_req = 1'b1;
      @(negedge clk);
    end
    apply_req = 1'b0; bypass_req = 1'b0; wr_en = 1'b0;
    chk(t_rf == BYP, "R4 reset/disable clear", t_rf, BYP);
    chk(t_rr == aoff + RST, (d <= BYP) ? "R6 held apply release" : "R5 apply release",
        t_rr, aoff + RST);
    chk(t_lk == aoff + RST + LOCK, "R7 lock time", t_lk, aoff + RST + LOCK);
    chk(t_dn == aoff + RST + LOCK + 1, "R8 oe/busy timing", t_dn, aoff + RST + LOCK + 1);
    chk(ctrl === END_WORD, disturb ? "R9 ignored requests/R2 write" : "R8 final word",
        ctrl, END_WORD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl === 9'h010, "R1 ctrl", ctrl, 9'h010);
    chk(busy === 1'b0 && locked === 1'b0, "R1 flags", {busy, locked}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    write_word(9'h0C6);
    chk(ctrl === 9'h0C6, "R2 idle write", ctrl, 9'h0C6);
    write_word(RUN_WORD);
    chk(ctrl === RUN_WORD, "R2 idle write", ctrl, RUN_WORD);
    // R7: lock after LOCK cycles of released reset
    repeat (LOCK - 1) @(negedge clk);
    chk(locked === 1'b0, "R7 not yet locked", locked, 0);
    @(negedge clk);
    chk(locked === 1'b1, "R7 locked", locked, 1);
    // R9: apply in idle ignored
    apply_req = 1'b1; @(negedge clk); apply_req = 1'b0;
    chk(busy === 1'b0 && ctrl === RUN_WORD, "R9 idle apply", ctrl, RUN_WORD);
    for (int d = 1; d <= BYP + 6; d++) begin
      write_word(RUN_WORD);
      repeat (LOCK + 1) @(negedge clk);
      run_seq(d, 1'b0);
    end
    write_word(RUN_WORD);
    repeat (LOCK + 1) @(negedge clk);
    run_seq(2, 1'b1);
    write_word(RUN_WORD);
    repeat (LOCK + 1) @(negedge clk);
    run_seq(BYP + 3, 1'b1);
    // R7: disable drops lock
    write_word(RUN_WORD | 9'h010);
    @(negedge clk);
    chk(locked === 1'b0, "R7 disable drops lock", locked, 0);
    // R10: request beats write in same cycle
    write_word(RUN_WORD);
    bypass_req = 1'b1; wr_en = 1'b1; wr_data = 9'h0FF;
    @(negedge clk);
    bypass_req = 1'b0; wr_en = 1'b0;
    chk(ctrl === (RUN_WORD & ~9'h021), "R10 request priority", ctrl, RUN_WORD & ~9'h021);
    chk(busy === 1'b1, "R10 busy", busy, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule